// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block watches a running BCD calendar and decides, once per second, whether the programmed alarm time has been reached. Four alarm bytes hold a seconds, minutes, hours and day-or-date value. The top bit of each byte is a mask bit, and the four mask bits together choose the alarm rate: every second, on a seconds match, on a minutes-and-seconds match, on an hours-minutes-seconds match, or on a full match that includes the day field. In the day byte, bit 6 chooses what the day field is compared against: the day of the month (bit 6 = 0) or the day of the week (bit 6 = 1).

The comparison is made only in the cycle where the update strobe is high. The calendar logic raises that strobe after the time has advanced. A qualifying match sets a sticky alarm flag. The interrupt request follows the flag whenever the interrupt enable is set. The flag is cleared by a read of the flags register or by a write of 0 to the flag.

A separate wake-up path raises a power request when the power enable is set and all four fields match exactly. This path ignores the mask bits and the interrupt enable. The request stays high until software drops the power enable.

Top module: `tod_alarm_cmp`

## Requirements
- R1: While reset is held, and in the first cycle after it, alarm_flag, irq_req and pwr_req are all 0.
- R2: With all four mask bits (bit 7 of each alarm byte) at 1, every strobe sets the flag, whatever the time values are.
- R3: Masks AM4..AM1 = 1110 set the flag on a strobe only when the current seconds equal the alarm seconds (bits 6:0).
- R4: Masks 1100 set the flag on a strobe only when both minutes and seconds match.
- R5: Masks 1000 set the flag on a strobe only when hours (bits 5:0), minutes and seconds all match.
- R6: Masks 0000 with bit 6 of the day byte at 0 need a match of bits 5:0 of the day byte against the day of month, plus hours, minutes and seconds.
- R7: Masks 0000 with bit 6 of the day byte at 1 need a match of bits 5:0 of the day byte against the zero-extended day of week; the day of month is then ignored.
- R8: Any mask pattern other than 1111, 1110, 1100, 1000 or 0000 behaves as once per second.
- R9: Without a strobe the flag is never set, even when the values match.
- R10: irq_req is 1 exactly when the flag is 1 and irq_en is 1.
- R11: With pwr_en at 1, a strobe during which all four fields match sets pwr_req one cycle later. This happens whatever the masks and irq_en are. pwr_req falls the cycle after pwr_en goes to 0.
- R12: The flag holds until flag_rd is pulsed or flag_wr is pulsed with flag_wdata = 0. A write of 1 leaves it set.
- R13: When a new match and a clear land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe, once per second, after the time has advanced |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD, 24-hour |
| cur_wday | input | 3 | Current day of week |
| cur_mday | input | 8 | Current day of month, BCD |
| alm_sec | input | 8 | Alarm seconds byte, bit 7 = AM1 |
| alm_min | input | 8 | Alarm minutes byte, bit 7 = AM2 |
| alm_hour | input | 8 | Alarm hours byte, bit 7 = AM3 |
| alm_day | input | 8 | Alarm day byte, bit 7 = AM4, bit 6 = day-of-week select |
| irq_en | input | 1 | Alarm interrupt enable |
| pwr_en | input | 1 | Wake-up power enable |
| flag_rd | input | 1 | Pulse: the flags register is being read |
| flag_wr | input | 1 | Pulse: write to the alarm flag |
| flag_wdata | input | 1 | Value written with flag_wr |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_req | output | 1 | Interrupt request |
| pwr_req | output | 1 | Wake-up power request |

## Verification
The bench builds the block with the default 8-bit register width and a 3-bit day-of-week field, so that bit 7 holds the mask and bit 6 the day select, as in the requirements. With these values every mask pattern the rate decoder handles can be reached directly. This includes the unlisted ones and the day-select bit, which sits right beside the compared day bits. For each rate, the bench changes one field away from its alarm value to show which fields take part in the match. It also covers the same-cycle set and clear case and a power request raised while the masks select a coarser rate.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

  typedef enum logic [2:0] {
    RATE_EACH_SEC = 3'd0,
    RATE_SEC      = 3'd1,
    RATE_MIN_SEC  = 3'd2,
    RATE_HMS      = 3'd3,
    RATE_FULL     = 3'd4
  } rate_e;

  // masks ordered {AM4, AM3, AM2, AM1}
  function automatic rate_e rate_from_masks(input logic [3:0] m);
    case (m)
      4'b1111: return RATE_EACH_SEC;
      4'b1110: return RATE_SEC;
      4'b1100: return RATE_MIN_SEC;
      4'b1000: return RATE_HMS;
      4'b0000: return RATE_FULL;
      default: return RATE_EACH_SEC;
    endcase
  endfunction

  // fm ordered {day, hour, min, sec}
  function automatic logic rate_satisfied(input rate_e r, input logic [3:0] fm);
    case (r)
      RATE_SEC:     return fm[0];
      RATE_MIN_SEC: return &fm[1:0];
      RATE_HMS:     return &fm[2:0];
      RATE_FULL:    return &fm;
      default:      return 1'b1;
    endcase
  endfunction

  // compared value width of field idx (0 sec, 1 min, 2 hour, 3 day)
  function automatic int unsigned field_vw(input int unsigned idx, input int unsigned dw);
    return (idx < 2) ? dw - 1 : dw - 2;
  endfunction

endpackage

// File: rtl/tod_alarm_field.sv
module tod_alarm_field #(
  parameter int DW = 8,
  parameter int VW = 7
) (
  input  logic [DW-1:0] areg,
  input  logic [VW-1:0] cur,
  output logic          mask,
  output logic          match
);
  assign mask  = areg[DW-1];
  assign match = (areg[VW-1:0] == cur);
endmodule

// File: rtl/tod_alarm_rate.sv
module tod_alarm_rate
  import tod_alarm_pkg::*;
(
  input  logic       tick,
  input  logic [3:0] masks,
  input  logic [3:0] fmatch,
  output logic       hit,
  output logic       full_hit
);
  rate_e rate;

  always_comb begin
    rate     = rate_from_masks(masks);
    hit      = tick & rate_satisfied(rate, fmatch);
    full_hit = tick & (&fmatch);
  end
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic full_hit,
  input  logic clr_req,
  input  logic pwr_en,
  output logic flag_q,
  output logic pwr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pwr_q  <= 1'b0;
    end else begin
      flag_q <= hit | (flag_q & ~clr_req);
      pwr_q  <= pwr_en & (pwr_q | full_hit);
    end
  end

  // R12: a set flag survives any cycle without a clear request
  a_r12_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);

  // R13: a qualifying match always leaves the flag set, clear or not
  a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  // R11: power request drops after the enable is removed
  a_r11_pwr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> !pwr_q);
endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
  import tod_alarm_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DAYW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [DW-1:0]   cur_sec,
  input  logic [DW-1:0]   cur_min,
  input  logic [DW-1:0]   cur_hour,
  input  logic [DAYW-1:0] cur_wday,
  input  logic [DW-1:0]   cur_mday,
  input  logic [DW-1:0]   alm_sec,
  input  logic [DW-1:0]   alm_min,
  input  logic [DW-1:0]   alm_hour,
  input  logic [DW-1:0]   alm_day,
  input  logic            irq_en,
  input  logic            pwr_en,
  input  logic            flag_rd,
  input  logic            flag_wr,
  input  logic            flag_wdata,
  output logic            alarm_flag,
  output logic            irq_req,
  output logic            pwr_req
);
  localparam int NF    = 4;
  localparam int DYSEL = DW - 2;

  logic [DW-1:0] areg  [NF];
  logic [DW-1:0] cur_v [NF];
  logic [NF-1:0] masks;
  logic [NF-1:0] fmatch;
  logic          day_sel;
  logic          hit;
  logic          full_hit;
  logic          clr_req;

  assign day_sel = alm_day[DYSEL];

  always_comb begin
    areg[0]  = alm_sec;
    areg[1]  = alm_min;
    areg[2]  = alm_hour;
    areg[3]  = alm_day;
    cur_v[0] = cur_sec;
    cur_v[1] = cur_min;
    cur_v[2] = cur_hour;
    cur_v[3] = day_sel ? DW'(cur_wday) : cur_mday;
  end

  for (genvar i = 0; i < NF; i++) begin : g_fld
    localparam int VW = int'(field_vw(i, DW));
    tod_alarm_field #(.DW(DW), .VW(VW)) u_fld (
      .areg (areg[i]),
      .cur  (cur_v[i][VW-1:0]),
      .mask (masks[i]),
      .match(fmatch[i])
    );
  end

  tod_alarm_rate u_rate (
    .tick    (tick),
    .masks   (masks),
    .fmatch  (fmatch),
    .hit     (hit),
    .full_hit(full_hit)
  );

  assign clr_req = flag_rd | (flag_wr & ~flag_wdata);

  tod_alarm_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .full_hit(full_hit),
    .clr_req (clr_req),
    .pwr_en  (pwr_en),
    .flag_q  (alarm_flag),
    .pwr_q   (pwr_req)
  );

  assign irq_req = alarm_flag & irq_en;

  // R9: flag only rises after a strobe
  a_r9_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick));

  // R2: all masks set means any strobe raises the flag
  a_r2_every_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (masks == 4'b1111)) |=> alarm_flag);

  // R11: power request rises only from a strobed full match
  a_r11_pwr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_req) |-> ($past(tick) && $past(pwr_en)));

  // R10: no interrupt while the enable is low
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_req);
endmodule

// File: tb/sim_tod_alarm_cmp.sv
module sim_tod_alarm_cmp;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_mday = '0;
  logic [2:0] cur_wday = '0;
  logic [7:0] alm_sec = '0, alm_min = '0, alm_hour = '0, alm_day = '0;
  logic irq_en = 1'b0, pwr_en = 1'b0, flag_rd = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic alarm_flag, irq_req, pwr_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_alarm_cmp u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .cur_mday(cur_mday),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .alm_day(alm_day),
    .irq_en(irq_en), .pwr_en(pwr_en), .flag_rd(flag_rd), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .alarm_flag(alarm_flag), .irq_req(irq_req), .pwr_req(pwr_req)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic set_alm(input logic [7:0] s, m, h, d);
    alm_sec = s; alm_min = m; alm_hour = h; alm_day = d;
  endtask

  task automatic set_now(input logic [7:0] s, m, h, input logic [2:0] wd, input logic [7:0] md);
    cur_sec = s; cur_min = m; cur_hour = h; cur_wday = wd; cur_mday = md;
  endtask

  task automatic strobe;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic clear_flag;
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 flag in reset", alarm_flag, 1'b0);
    chk("R1 pwr in reset", pwr_req, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flag after reset", alarm_flag, 1'b0);
    chk("R1 irq after reset", irq_req, 1'b0);
    chk("R1 pwr after reset", pwr_req, 1'b0);
  endtask

  task automatic t_every;
    set_alm(8'h80, 8'h81, 8'h82, 8'h83);
    set_now(8'h17, 8'h29, 8'h11, 3'd6, 8'h19);
    strobe; chk("R2 every second", alarm_flag, 1'b1);
    clear_flag; chk("R12 read clears", alarm_flag, 1'b0);
  endtask

  task automatic t_sec;
    set_alm(8'h30, 8'h85, 8'h80, 8'h80);
    set_now(8'h30, 8'h12, 8'h07, 3'd2, 8'h05);
    strobe; chk("R3 seconds match", alarm_flag, 1'b1);
    clear_flag;
    cur_sec = 8'h31;
    strobe; chk("R3 seconds differ", alarm_flag, 1'b0);
  endtask

  task automatic t_minsec;
    set_alm(8'h15, 8'h42, 8'h80, 8'h80);
    set_now(8'h15, 8'h42, 8'h09, 3'd1, 8'h22);
    strobe; chk("R4 min+sec match", alarm_flag, 1'b1);
    clear_flag;
    cur_min = 8'h43;
    strobe; chk("R4 minutes differ", alarm_flag, 1'b0);
  endtask

  task automatic t_hms;
    set_alm(8'h05, 8'h59, 8'h23, 8'h80);
    set_now(8'h05, 8'h59, 8'h23, 3'd3, 8'h11);
    strobe; chk("R5 h:m:s match", alarm_flag, 1'b1);
    clear_flag;
    cur_hour = 8'h22;
    strobe; chk("R5 hours differ", alarm_flag, 1'b0);
  endtask

  task automatic t_date;
    set_alm(8'h00, 8'h00, 8'h12, 8'h31);
    set_now(8'h00, 8'h00, 8'h12, 3'd7, 8'h31);
    strobe; chk("R6 date match", alarm_flag, 1'b1);
    clear_flag;
    cur_mday = 8'h30;
    strobe; chk("R6 date differs", alarm_flag, 1'b0);
  endtask

  task automatic t_day;
    set_alm(8'h00, 8'h00, 8'h12, 8'h45);
    set_now(8'h00, 8'h00, 8'h12, 3'd5, 8'h17);
    strobe; chk("R7 weekday match", alarm_flag, 1'b1);
    clear_flag;
    cur_wday = 3'd4; cur_mday = 8'h05;
    strobe; chk("R7 weekday differs", alarm_flag, 1'b0);
  endtask

  task automatic t_unlisted;
    set_alm(8'h81, 8'h02, 8'h83, 8'h04);
    set_now(8'h50, 8'h50, 8'h20, 3'd0, 8'h28);
    strobe; chk("R8 unlisted masks", alarm_flag, 1'b1);
    clear_flag;
  endtask

  task automatic t_notick;
    set_alm(8'h80, 8'h80, 8'h80, 8'h80);
    repeat (5) @(negedge clk);
    chk("R9 no strobe no flag", alarm_flag, 1'b0);
  endtask

  task automatic t_irq;
    set_alm(8'h80, 8'h80, 8'h80, 8'h80);
    irq_en = 1'b0;
    strobe;
    chk("R10 flag set", alarm_flag, 1'b1);
    chk("R10 irq gated off", irq_req, 1'b0);
    irq_en = 1'b1; #1;
    chk("R10 irq enabled", irq_req, 1'b1);
    clear_flag;
    chk("R10 irq after clear", irq_req, 1'b0);
    irq_en = 1'b0;
  endtask

  task automatic t_pwr;
    set_alm(8'h80 | 8'h10, 8'h80 | 8'h20, 8'h80 | 8'h08, 8'h80 | 8'h14);
    set_now(8'h10, 8'h20, 8'h09, 3'd1, 8'h14);
    pwr_en = 1'b1; irq_en = 1'b0;
    strobe;
    chk("R11 no pwr on partial", pwr_req, 1'b0);
    clear_flag;
    cur_hour = 8'h08;
    strobe;
    chk("R11 pwr on full match", pwr_req, 1'b1);
    chk("R11 irq still off", irq_req, 1'b0);
    @(negedge clk);
    chk("R11 pwr holds", pwr_req, 1'b1);
    pwr_en = 1'b0;
    @(negedge clk);
    chk("R11 pwr drops", pwr_req, 1'b0);
    clear_flag;
  endtask

  task automatic t_clear;
    set_alm(8'h80, 8'h80, 8'h80, 8'h80);
    strobe;
    flag_wr = 1'b1; flag_wdata = 1'b1;
    @(negedge clk);
    flag_wr = 1'b0;
    chk("R12 write one keeps", alarm_flag, 1'b1);
    repeat (3) @(negedge clk);
    chk("R12 holds", alarm_flag, 1'b1);
    flag_wr = 1'b1; flag_wdata = 1'b0;
    @(negedge clk);
    flag_wr = 1'b0;
    chk("R12 write zero clears", alarm_flag, 1'b0);
  endtask

  task automatic t_race;
    set_alm(8'h80, 8'h80, 8'h80, 8'h80);
    strobe;
    flag_rd = 1'b1; tick = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0; tick = 1'b0;
    chk("R13 set beats clear", alarm_flag, 1'b1);
    clear_flag;
    chk("R13 later clear", alarm_flag, 1'b0);
  endtask

  initial begin
    t_reset;
    t_every;
    t_sec;
    t_minsec;
    t_hms;
    t_date;
    t_day;
    t_unlisted;
    t_notick;
    t_irq;
    t_pwr;
    t_clear;
    t_race;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule